// File: doc/BRIEF.md
# Prescaled Compare Timer with Day Mode

This block is a free-running up-counter for timekeeping and periodic events. A prescaler advances on an external tick enable and offers three power-of-two taps. A fixed divider on the system clock gives a fourth source. A two-bit select in the control word picks which of these four sources advances the counter. Software can read the counter value on every cycle without stopping it.

A compare register holds a match value. When the counter steps onto that value, the block emits a one-cycle interrupt pulse. A control write can clear the counter, the prescaler and the divider in one cycle. Day mode ends the count early: the counter returns to zero one step after its top bit is set and its low bits equal the compare value. With the default width and a compare value of 0x517F, the counter therefore counts modulo 86400.

The block uses a single clock. All rate control is done with clock enables.

Top module: `presc_day_timer`

## Requirements
- R1: After reset the count is 0, the interrupt is low and counting is disabled, so tick enables do not move the count.
- R2: With select 00 and counting enabled, the count advances once every MAIN_DIV (32) clocks, whatever the tick-enable input does.
- R3: With selects 11, 10 and 01, the count advances once per 2^3, 2^9 and 2^15 tick enables respectively.
- R4: While the run bit (control word bit 2) is 0, the count holds its value.
- R5: A control write with bit 3 set clears the count, the prescaler and the divider on that edge. This takes priority over a step. The bit is not stored, so counting resumes afterwards from a fresh prescaler phase.
- R6: Outside day mode, a step that lands on a count whose low CNT_W-1 bits equal the compare value raises the interrupt for exactly one cycle. The top counter bit is ignored in this comparison.
- R7: Outside day mode, the count wraps from all ones to 0.
- R8: In day mode (control word bit 4), a step taken from a count whose top bit is 1 and whose low bits equal the compare value goes to 0, and the interrupt rises together with that wrap. A low-bit match with the top bit 0 neither wraps the count nor raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_tick | input | 1 | Prescaler advance enable |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | [1:0] source select, [2] run, [3] clear, [4] day mode |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | CNT_W-1 | Compare value |
| count | output | CNT_W | Live counter value |
| irq | output | 1 | One-cycle compare interrupt |

## Verification
The day-mode wrap is the hardest case to reach. It needs the top counter bit set, and the counter has no load port. At the default width, that means 65536 or more steps, each at least eight clocks long. To reach it, the bench runs a second instance with a 9-bit counter and an 8-bit compare, driven by the same stimulus. That instance reaches its wrap in a few thousand clocks through the fastest tap. The same narrow instance also covers the natural wrap and shows that the compare ignores the top bit.

// File: rtl/presc_day_timer.sv
module presc_day_timer #(
  parameter int CNT_W    = 17,
  parameter int PRE_W    = 15,
  parameter int MAIN_DIV = 32,
  parameter int TAP_LO   = 3,
  parameter int TAP_MID  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pre_tick,
  input  logic             ctl_we,
  input  logic [4:0]       ctl_wdata,
  input  logic             cmp_we,
  input  logic [CNT_W-2:0] cmp_wdata,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  localparam int CMP_W = CNT_W - 1;
  localparam int DIV_W = $clog2(MAIN_DIV);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(MAIN_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       sel_q;
  logic             run_q, day_q, irq_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CMP_W-1:0] cmp_q;
  logic             tick, step, top_match, hit;

  wire clr = ctl_we & ctl_wdata[3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pre_q <= '0;
    else if (clr)      pre_q <= '0;
    else if (pre_tick) pre_q <= pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                div_q <= '0;
    else if (clr)              div_q <= '0;
    else if (div_q == DIV_LAST) div_q <= '0;
    else                       div_q <= div_q + 1'b1;

  always_comb
    case (sel_q)
      2'b00:   tick = (div_q == DIV_LAST);
      2'b01:   tick = pre_tick & (&pre_q);
      2'b10:   tick = pre_tick & (&pre_q[TAP_MID-1:0]);
      default: tick = pre_tick & (&pre_q[TAP_LO-1:0]);
    endcase

  assign step      = run_q & tick;
  assign top_match = cnt_q[CNT_W-1] && (cnt_q[CMP_W-1:0] == cmp_q);
  assign cnt_nxt   = (day_q && top_match) ? '0 : cnt_q + 1'b1;
  assign hit       = day_q ? top_match : (cnt_nxt[CMP_W-1:0] == cmp_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= 2'b00;
      run_q <= 1'b0;
      day_q <= 1'b0;
    end else if (ctl_we) begin
      sel_q <= ctl_wdata[1:0];
      run_q <= ctl_wdata[2];
      day_q <= ctl_wdata[4];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cmp_q <= '0;
    else if (cmp_we) cmp_q <= cmp_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= !clr && step && hit;
      if (clr)       cnt_q <= '0;
      else if (step) cnt_q <= cnt_nxt;
    end

  assign count = cnt_q;
  assign irq   = irq_q;

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && (pre_q == '0) && !irq_q);

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !clr) |=> $stable(cnt_q));

  assert_irq_on_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(step));

  assert_step_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(step) && !$past(clr)) |-> ((cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == '0)));
endmodule

// File: tb/sim_presc_day_timer.sv
module sim_presc_day_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, pre_tick = 1'b0;
  logic        ctl_we = 1'b0, cmp_we = 1'b0;
  logic [4:0]  ctl_wdata = '0;
  logic [15:0] cmp0 = '0;
  logic [7:0]  cmp1 = '0;
  logic [16:0] cnt0;
  logic [8:0]  cnt1;
  logic        irq0, irq1;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  presc_day_timer u0 (.clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp0), .count(cnt0), .irq(irq0));

  presc_day_timer #(.CNT_W(9)) u1 (.clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp1), .count(cnt1), .irq(irq1));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_e(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_ctl(input logic [1:0] sel, input logic run, input logic clr, input logic day);
    ctl_we = 1'b1;
    ctl_wdata = {day, clr, run, sel};
    wait_e(1);
    ctl_we = 1'b0;
  endtask

  task automatic wr_cmp(input logic [15:0] a, input logic [7:0] b);
    cmp_we = 1'b1; cmp0 = a; cmp1 = b;
    wait_e(1);
    cmp_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 count", cnt0, 0);
    chk("R1 irq", irq0, 0);
    pre_tick = 1'b1;
    wait_e(40);
    chk("R1 idle count", cnt0, 0);
  endtask

  task automatic t_main32;
    pre_tick = 1'b0;
    wr_ctl(2'b00, 1, 1, 0);
    wait_e(95);
    chk("R2 before step", cnt0, 2);
    wait_e(1);
    chk("R2 third step", cnt0, 3);
  endtask

  task automatic t_taps;
    pre_tick = 1'b1;
    wr_ctl(2'b11, 1, 1, 0);
    wait_e(40);
    chk("R3 tap 2^3", cnt0, 5);
    wr_ctl(2'b10, 1, 1, 0);
    wait_e(1024);
    chk("R3 tap 2^9", cnt0, 2);
    wr_ctl(2'b01, 1, 1, 0);
    wait_e(32767);
    chk("R3 tap 2^15 before", cnt0, 0);
    wait_e(1);
    chk("R3 tap 2^15", cnt0, 1);
  endtask

  task automatic t_hold;
    wr_ctl(2'b11, 1, 1, 0);
    wait_e(24);
    chk("R4 running", cnt0, 3);
    wr_ctl(2'b11, 0, 0, 0);
    wait_e(80);
    chk("R4 held", cnt0, 3);
  endtask

  task automatic t_clr;
    wr_ctl(2'b11, 1, 1, 0);
    wait_e(11);
    chk("R5 pre count", cnt0, 1);
    wr_ctl(2'b11, 1, 1, 0);
    chk("R5 cleared", cnt0, 0);
    wait_e(7);
    chk("R5 prescaler phase", cnt0, 0);
    wait_e(1);
    chk("R5 resumed", cnt0, 1);
  endtask

  task automatic t_irq;
    wr_cmp(16'd5, 8'd0);
    wr_ctl(2'b11, 1, 1, 0);
    wait_e(39);
    chk("R6 no irq early", irq0, 0);
    wait_e(1);
    chk("R6 count at match", cnt0, 5);
    chk("R6 irq", irq0, 1);
    wait_e(1);
    chk("R6 one cycle", irq0, 0);
  endtask

  task automatic t_wrap;
    wr_ctl(2'b11, 1, 1, 0);
    wait_e(8*256);
    chk("R6 top bit ignored count", cnt1, 256);
    chk("R6 top bit ignored irq", irq1, 1);
    wait_e(8*256);
    chk("R7 natural wrap", cnt1, 0);
    chk("R7 wrap irq", irq1, 1);
  endtask

  task automatic t_day;
    wr_cmp(16'h517F, 8'h10);
    wr_ctl(2'b11, 1, 1, 1);
    wait_e(8*16);
    chk("R8 low match count", cnt1, 16);
    chk("R8 low match no irq", irq1, 0);
    wait_e(8*256);
    chk("R8 at end value", cnt1, 272);
    chk("R8 no irq before wrap", irq1, 0);
    wait_e(8);
    chk("R8 day wrap", cnt1, 0);
    chk("R8 irq with wrap", irq1, 1);
    wait_e(8);
    chk("R8 after wrap", cnt1, 1);
  endtask

  initial begin
    wait_e(3);
    rst_n = 1'b1;
    wait_e(1);
    t_reset();
    t_main32();
    t_taps();
    t_hold();
    t_clr();
    t_irq();
    t_wrap();
    t_day();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule